// File: doc/BRIEF.md
# Interrupt Message Write Decoder and Destination Matcher

This block sits on a 32-bit memory write path and looks at every DWORD write. A write whose address falls in the fixed interrupt-message window (upper twelve address bits equal to `12'hFEE`) is taken as an interrupt message. Any other write is handed, unchanged and in the same cycle, to a separate pass-through port. For a message, the block reads the destination ID, the redirection hint and the destination mode from the address. It then compares them with the static identity of the local interrupt unit: a physical ID, a logical ID and a flat/cluster selector.

A message that targets this unit is loaded into a one-entry output slot together with its 32-bit data word. It stays there until the consumer takes it through a valid/ready handshake. A message that does not target the unit is consumed and has no effect. A message that sets the hint but names the all-ones destination in physical or cluster mode is illegal. It is dropped and reported by a one-cycle error pulse.

The slot is controlled by a two-state machine. `S_IDLE` means the slot is empty and a window write may be accepted. `S_HOLD` means a message is waiting for the consumer. There are two transitions. `S_IDLE` goes to `S_HOLD` ("load") when a delivered message is accepted. `S_HOLD` goes back to `S_IDLE` ("drain") when `irq_ready` is high. While in `S_HOLD`, window writes are stalled.

Top module: `msi_decode_top`

## Requirements
- R1: A write with `wr_addr[31:20] != 12'hFEE` is presented combinationally on `pass_valid`/`pass_addr`/`pass_data` with address and data unchanged, and `wr_ready` follows `pass_ready` for it; such writes never produce `irq_valid` or `irq_err`.
- R2: For a window write the destination is `wr_addr[19:12]`, the hint is `wr_addr[3]` and the mode is `wr_addr[2]` (1 = logical); a delivered message shows them on `irq_dest`, `irq_hint`, `irq_logical` and carries `wr_data` unchanged on `irq_data`; address bits 11:4 and 1:0 have no effect.
- R3: In physical mode (`wr_addr[2]=0`) a message is delivered when the destination equals `cfg_phys_id`, or when the destination is 8'hFF with the hint clear (broadcast).
- R4: In logical flat mode (`cfg_cluster=0`) a message is delivered when the destination AND `cfg_log_id` is nonzero.
- R5: In logical cluster mode (`cfg_cluster=1`) a message is delivered when the upper nibbles of destination and `cfg_log_id` are equal and their lower nibbles share at least one set bit.
- R6: A message with the hint set and destination 8'hFF in physical mode or in logical cluster mode is not delivered, and `irq_err` is high for exactly the one cycle after its acceptance; in flat mode the same message follows R4 with no error.
- R7: `irq_valid` rises in the cycle after the accepting edge and stays high with `irq_dest`, `irq_hint`, `irq_logical` and `irq_data` stable until a cycle with `irq_ready` high, after which it falls.
- R8: While `irq_valid` is high, `wr_ready` is low for window writes, so a pending message is never overwritten or lost; pass-through writes are not stalled.
- R9: A window write that matches nothing is accepted with `wr_ready` high and leaves `irq_valid` and `irq_err` low.
- R10: After reset `irq_valid` and `irq_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted when high with wr_valid |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 32 | Write data word |
| pass_valid | output | 1 | Non-interrupt write valid |
| pass_ready | input | 1 | Pass-through consumer ready |
| pass_addr | output | 32 | Pass-through address |
| pass_data | output | 32 | Pass-through data |
| cfg_phys_id | input | 8 | Local physical ID |
| cfg_log_id | input | 8 | Local logical ID |
| cfg_cluster | input | 1 | Logical model: 0 flat, 1 cluster |
| irq_valid | output | 1 | Delivered message pending |
| irq_ready | input | 1 | Consumer takes the message |
| irq_dest | output | 8 | Destination ID of message |
| irq_hint | output | 1 | Redirection hint of message |
| irq_logical | output | 1 | Destination mode of message |
| irq_data | output | 32 | Message data word |
| irq_err | output | 1 | Illegal-destination pulse |

## Verification
Pass-through results are combinational, so the bench drives a write on a falling edge and reads the pass port and `wr_ready` in that same half cycle. A message accepted at a rising edge shows up on `irq_valid`, and an illegal one on `irq_err`, after exactly one register stage. The bench therefore samples them on the falling edge that directly follows the accepting edge, and samples again one cycle later to confirm that the error pulse lasts one cycle. Hold and drain behaviour is checked on every falling edge while `irq_ready` is toggled.

// File: rtl/msi_pkg.sv
package msi_pkg;
    localparam int DEST_W = 8;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              hint;
        logic              logical;
    } msi_fields_t;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } slot_state_e;
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
    import msi_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          TAG_W    = 12,
    parameter logic [11:0] TAG      = 12'hFEE,
    parameter int          DEST_LSB = 12,
    parameter int          HINT_BIT = 3,
    parameter int          MODE_BIT = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output msi_fields_t       fields
);
    localparam int TAG_LSB = ADDR_W - TAG_W;

    always_comb begin
        hit            = (addr[ADDR_W-1:TAG_LSB] == TAG[TAG_W-1:0]);
        fields.dest    = addr[DEST_LSB +: DEST_W];
        fields.hint    = addr[HINT_BIT];
        fields.logical = addr[MODE_BIT];
    end
endmodule

// File: rtl/msi_dest_match.sv
module msi_dest_match
    import msi_pkg::*;
(
    input  msi_fields_t       fields,
    input  logic [DEST_W-1:0] cfg_phys_id,
    input  logic [DEST_W-1:0] cfg_log_id,
    input  logic              cfg_cluster,
    output logic              deliver,
    output logic              illegal
);
    localparam int NIB = DEST_W / 2;
    localparam logic [DEST_W-1:0] ALL_ONES = {DEST_W{1'b1}};

    logic all_ones;
    logic phys_hit;
    logic flat_hit;
    logic clus_hit;
    logic match;

    always_comb begin
        all_ones = (fields.dest == ALL_ONES);
        phys_hit = (fields.dest == cfg_phys_id) || (all_ones && !fields.hint);
        flat_hit = |(fields.dest & cfg_log_id);
        clus_hit = (fields.dest[DEST_W-1:NIB] == cfg_log_id[DEST_W-1:NIB])
                   && |(fields.dest[NIB-1:0] & cfg_log_id[NIB-1:0]);
        unique case ({fields.logical, cfg_cluster})
            2'b00, 2'b01: match = phys_hit;
            2'b10:        match = flat_hit;
            2'b11:        match = clus_hit;
            default:      match = 1'b0;
        endcase
        illegal = fields.hint && all_ones && (!fields.logical || cfg_cluster);
        deliver = match && !illegal;
    end
endmodule

// File: rtl/msi_out_slot.sv
module msi_out_slot
    import msi_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  msi_fields_t       load_fields,
    input  logic [DATA_W-1:0] load_data,
    output logic              slot_free,
    output logic              out_valid,
    input  logic              out_ready,
    output msi_fields_t       out_fields,
    output logic [DATA_W-1:0] out_data
);
    slot_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (load)      state_d = S_HOLD;
            S_HOLD: if (out_ready) state_d = S_IDLE;
            default:               state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_fields <= '0;
            out_data   <= '0;
        end else if (load && state_q == S_IDLE) begin
            out_fields <= load_fields;
            out_data   <= load_data;
        end
    end

    always_comb begin
        slot_free = (state_q == S_IDLE);
        out_valid = (state_q == S_HOLD);
    end

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_fields)));

    assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);

    assert_rise_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(load));
endmodule

// File: rtl/msi_decode_top.sv
module msi_decode_top
    import msi_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pass_valid,
    input  logic              pass_ready,
    output logic [ADDR_W-1:0] pass_addr,
    output logic [DATA_W-1:0] pass_data,
    input  logic [7:0]        cfg_phys_id,
    input  logic [7:0]        cfg_log_id,
    input  logic              cfg_cluster,
    output logic              irq_valid,
    input  logic              irq_ready,
    output logic [7:0]        irq_dest,
    output logic              irq_hint,
    output logic              irq_logical,
    output logic [DATA_W-1:0] irq_data,
    output logic              irq_err
);
    logic        hit;
    logic        deliver;
    logic        illegal;
    logic        slot_free;
    logic        accept_msg;
    logic        load;
    msi_fields_t fields;
    msi_fields_t held;

    msi_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (wr_addr),
        .hit    (hit),
        .fields (fields)
    );

    msi_dest_match u_match (
        .fields      (fields),
        .cfg_phys_id (cfg_phys_id),
        .cfg_log_id  (cfg_log_id),
        .cfg_cluster (cfg_cluster),
        .deliver     (deliver),
        .illegal     (illegal)
    );

    always_comb begin
        wr_ready   = hit ? slot_free : pass_ready;
        pass_valid = wr_valid && !hit;
        pass_addr  = wr_addr;
        pass_data  = wr_data;
        accept_msg = wr_valid && hit && slot_free;
        load       = accept_msg && deliver;
    end

    msi_out_slot #(.DATA_W(DATA_W)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_fields (fields),
        .load_data   (wr_data),
        .slot_free   (slot_free),
        .out_valid   (irq_valid),
        .out_ready   (irq_ready),
        .out_fields  (held),
        .out_data    (irq_data)
    );

    always_comb begin
        irq_dest    = held.dest;
        irq_hint    = held.hint;
        irq_logical = held.logical;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_err <= 1'b0;
        else        irq_err <= accept_msg && illegal;
    end

    assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && wr_valid && hit) |-> !wr_ready);

    assert_err_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> $past(wr_valid && wr_ready));

    assert_err_no_delivery_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> !$rose(irq_valid));

    assert_pass_flow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_valid && pass_ready) |-> (wr_ready && !accept_msg));
endmodule

// File: tb/msi_decode_top_tb_top.sv
module msi_decode_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pass_valid;
    logic        pass_ready = 1'b1;
    logic [31:0] pass_addr;
    logic [31:0] pass_data;
    logic [7:0]  cfg_phys_id = 8'h23;
    logic [7:0]  cfg_log_id = 8'h0C;
    logic        cfg_cluster = 1'b0;
    logic        irq_valid;
    logic        irq_ready = 1'b0;
    logic [7:0]  irq_dest;
    logic        irq_hint;
    logic        irq_logical;
    logic [31:0] irq_data;
    logic        irq_err;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    msi_decode_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .pass_valid(pass_valid), .pass_ready(pass_ready), .pass_addr(pass_addr), .pass_data(pass_data),
        .cfg_phys_id(cfg_phys_id), .cfg_log_id(cfg_log_id), .cfg_cluster(cfg_cluster),
        .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_dest(irq_dest),
        .irq_hint(irq_hint), .irq_logical(irq_logical), .irq_data(irq_data), .irq_err(irq_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive a write and hold it until the accepting edge; returns just after that edge
    task automatic send(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_addr  = a;
        wr_data  = d;
        wr_valid = 1'b1;
        while (!wr_ready) @(negedge clk);
        @(posedge clk);
        #1 wr_valid = 1'b0;
    endtask

    // one-cycle result window after acceptance, then drain
    task automatic expect_msg(input string tag, input logic [7:0] dest, input logic h,
                              input logic m, input logic [31:0] d);
        @(negedge clk);
        chk({tag, " valid"}, irq_valid, 1);
        chk({tag, " dest"}, irq_dest, dest);
        chk({tag, " hint/mode"}, {irq_hint, irq_logical}, {h, m});
        chk({tag, " data"}, irq_data, d);
        chk({tag, " err"}, irq_err, 0);
        irq_ready = 1'b1;
        @(posedge clk);
        #1 irq_ready = 1'b0;
        @(negedge clk);
        chk({tag, " drained"}, irq_valid, 0);
    endtask

    task automatic expect_none(input string tag, input logic err);
        @(negedge clk);
        chk({tag, " no valid"}, irq_valid, 0);
        chk({tag, " err"}, irq_err, err);
        @(negedge clk);
        chk({tag, " err after"}, irq_err, 0);
        chk({tag, " still no valid"}, irq_valid, 0);
    endtask

    task automatic t_reset;
        chk("R10 irq_valid", irq_valid, 0);
        chk("R10 irq_err", irq_err, 0);
    endtask

    task automatic t_pass;
        @(negedge clk);
        wr_addr = 32'h1234_5678; wr_data = 32'hCAFE_0001; wr_valid = 1'b1; pass_ready = 1'b1;
        #0.5;
        chk("R1 pass_valid", pass_valid, 1);
        chk("R1 pass_addr", pass_addr, 32'h1234_5678);
        chk("R1 pass_data", pass_data, 32'hCAFE_0001);
        chk("R1 ready follows", wr_ready, 1);
        pass_ready = 1'b0;
        #0.5;
        chk("R1 ready low", wr_ready, 0);
        wr_addr = 32'hFEF0_0000; pass_ready = 1'b1;
        #0.5;
        chk("R1 edge of window passes", pass_valid, 1);
        @(posedge clk);
        #1 wr_valid = 1'b0;
        @(negedge clk);
        chk("R1 no irq", irq_valid, 0);
        chk("R1 no err", irq_err, 0);
    endtask

    task automatic t_phys;
        cfg_phys_id = 8'h23;
        send(32'hFEE2_3FF3, 32'hAAAA_0001);
        expect_msg("R2 R3 phys exact", 8'h23, 0, 0, 32'hAAAA_0001);
        send(32'hFEE2_3008, 32'hAAAA_0002);
        expect_msg("R3 phys hint", 8'h23, 1, 0, 32'hAAAA_0002);
        send(32'hFEEF_F000, 32'hAAAA_0003);
        expect_msg("R3 broadcast", 8'hFF, 0, 0, 32'hAAAA_0003);
        send(32'hFEE2_4000, 32'hAAAA_0004);
        expect_none("R9 phys miss", 0);
        send(32'hFEEF_F008, 32'hAAAA_0005);
        expect_none("R6 phys FF hint", 1);
    endtask

    task automatic t_flat;
        cfg_cluster = 1'b0; cfg_log_id = 8'h0C;
        send(32'hFEE0_4004, 32'hBBBB_0001);
        expect_msg("R4 flat hit", 8'h04, 0, 1, 32'hBBBB_0001);
        send(32'hFEE3_0004, 32'hBBBB_0002);
        expect_none("R4 flat miss", 0);
        send(32'hFEEF_F00C, 32'hBBBB_0003);
        expect_msg("R6 flat FF legal", 8'hFF, 1, 1, 32'hBBBB_0003);
    endtask

    task automatic t_cluster;
        cfg_cluster = 1'b1; cfg_log_id = 8'h52;
        send(32'hFEE5_3004, 32'hCCCC_0001);
        expect_msg("R5 cluster hit", 8'h53, 0, 1, 32'hCCCC_0001);
        send(32'hFEE6_2004, 32'hCCCC_0002);
        expect_none("R5 cluster wrong group", 0);
        send(32'hFEE5_1004, 32'hCCCC_0003);
        expect_none("R5 cluster no member", 0);
        send(32'hFEEF_F00C, 32'hCCCC_0004);
        expect_none("R6 cluster FF hint", 1);
        send(32'hFEEF_F004, 32'hCCCC_0005);
        expect_none("R5 cluster FF no hint", 0);
        cfg_cluster = 1'b0;
    endtask

    task automatic t_backpressure;
        cfg_phys_id = 8'h23;
        send(32'hFEE2_3000, 32'hDDDD_0001);
        repeat (3) begin
            @(negedge clk);
            chk("R7 held valid", irq_valid, 1);
            chk("R7 held data", irq_data, 32'hDDDD_0001);
        end
        wr_addr = 32'hFEE2_3000; wr_data = 32'hDDDD_0002; wr_valid = 1'b1;
        #0.5;
        chk("R8 window stalled", wr_ready, 0);
        wr_addr = 32'h0000_1000;
        #0.5;
        chk("R8 pass not stalled", wr_ready, 1);
        wr_addr = 32'hFEE2_3000;
        @(negedge clk);
        chk("R8 first kept", irq_data, 32'hDDDD_0001);
        irq_ready = 1'b1;
        @(posedge clk);
        #1 irq_ready = 1'b0;
        @(negedge clk);
        chk("R7 drained", irq_valid, 0);
        chk("R8 ready after drain", wr_ready, 1);
        @(posedge clk);
        #1 wr_valid = 1'b0;
        expect_msg("R8 second delivered", 8'h23, 0, 0, 32'hDDDD_0002);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_pass();
        t_phys();
        t_flat();
        t_cluster();
        t_backpressure();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule